// File: doc/BRIEF.md
# Multi-Converter Sync Sequencer

This block lines up the conversion instants of several delta-sigma converters that share one serial clock wire. Normally the wire carries the SPI master's clock. When a sync is requested, the sequencer takes the wire over and holds it high. The converters treat a long high level on that wire as a sync trigger. The sequencer then waits until they have all entered their sync state, drives the wire low for one cycle, and gives it back to the SPI master. From then on the data-ready falling edges of all the converters are aligned.

A conversion period is 384 master clocks. The wire must stay high for at least four conversion periods, counted from a data-ready falling edge, and for no more than twenty. There are two ways to measure the wait:

- **Edge mode** counts five synchronized data-ready falling edges. The extra edge covers a conversion that was already running when the wire went high. A watchdog guards this mode.
- **Timer mode** holds the wire high for a programmed number of master clocks. That number must lie inside the allowed window.

An optional periodic trigger starts the sequence again and again. This suits boards where each converter runs from its own clock.

Top module: `adc_sync_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `sclk_out` equals `spi_sclk`.
- R2: An accepted request makes `sclk_out` 1 and `busy` 1 from the next cycle on. `sclk_out` stays 1 for the whole hold, whatever the level of `spi_sclk`.
- R3: In timer mode (`mode_timer`=1), the hold lasts exactly `wait_cfg` master clocks. The accepted boundary values 1920 and 7680 are included.
- R4: In timer mode, a request is rejected when `wait_cfg` is below 1920 (5×384) or above 7680 (20×384). On a rejected request, `busy` stays 0, `err` becomes 1 and `sclk_out` keeps following `spi_sclk`.
- R5: In edge mode (`mode_timer`=0), `drdy_n` is active low. The hold ends on the fifth falling edge of `drdy_n` seen during the hold. `sclk_out` goes low after the second clock edge that follows the edge which first samples `drdy_n` low.
- R6: Falling edges of `drdy_n` seen while idle are not counted toward the five.
- R7: In edge mode, if five edges have not arrived after 7680 clocks of hold, the hold ends at exactly 7680 clocks and `err` becomes 1.
- R8: After the hold there is one cycle with `sclk_out`=0 and `busy`=1. It is followed by one cycle with `done`=1. `done` is a single-cycle pulse. After `done`, `busy` returns to 0 and `sclk_out` follows `spi_sclk` again.
- R9: A request raised while `busy` is 1 is ignored: the hold length does not change.
- R10: While `resync_en` is 1 and the block is idle, a sequence starts by itself after RESYNC_CLKS idle clocks.
- R11: `err` is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Active-low reset |
| sync_req | input | 1 | Request to start a sync sequence |
| drdy_n | input | 1 | Data-ready from a converter, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock from the SPI master |
| mode_timer | input | 1 | 1 = timer mode, 0 = edge-count mode |
| wait_cfg | input | WAIT_W | Hold length in master clocks for timer mode |
| resync_en | input | 1 | Enables the periodic re-trigger |
| sclk_out | output | 1 | Serial clock wire driven to the converters |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | Rejected wait value or watchdog expiry |

## Verification
Timer mode is run at both window limits. One run keeps `spi_sclk` low and the other keeps it high, so a hold that leaks the SPI clock shows up as a mismatch. Timer mode is also run with values just outside the window, which tells a rejected request apart from one that was clamped or accepted.

Edge mode is run with a stray edge before the request and then five edges during the hold. The third sample after the fifth edge pins down the synchronizer latency and the counter threshold. Running it with only two edges separates the watchdog path from normal completion.

A request pulsed in the middle of a hold, and a periodic trigger with a known idle period, show whether a restart or a wrong trigger count changes the measured hold and idle lengths.

// File: rtl/adc_sync_pkg.sv
package adc_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_DONE    = 2'd3
    } sync_state_e;
endpackage

// File: rtl/drdy_fall_det.sv
// Two-flop synchronizer followed by a falling-edge detector.
// The fall pulse is high for one cycle.
module drdy_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic drdy_n,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = drdy_n;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        q <= d;
    end

    assign fall = q.s3 & ~q.s2;

    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/resync_timer.sv
// Raises a trigger after PERIOD consecutive idle clocks while enabled.
module resync_timer #(
    parameter int PERIOD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic busy,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en || busy || cnt_q == LAST) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && !busy && (cnt_q == LAST);

    assert_tick_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(en));
endmodule

// File: rtl/sync_ctrl_fsm.sv
// State machine that runs the hold, release and done phases.
module sync_ctrl_fsm
    import adc_sync_pkg::*;
#(
    parameter int CONV_CLKS   = 384,
    parameter int MIN_CONV    = 5,
    parameter int MAX_CONV    = 20,
    parameter int EDGE_TARGET = 5,
    parameter int CNT_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             tmode_in,
    input  logic [CNT_W-1:0] wait_in,
    input  logic             fall,
    input  logic             spi_sclk,
    output logic             sclk_out,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int MIN_CLKS = MIN_CONV * CONV_CLKS;
    localparam int MAX_CLKS = MAX_CONV * CONV_CLKS;
    localparam int EDGE_W   = $clog2(EDGE_TARGET + 1);
    localparam logic [CNT_W-1:0]  MIN_L  = CNT_W'(MIN_CLKS);
    localparam logic [CNT_W-1:0]  MAX_L  = CNT_W'(MAX_CLKS);
    localparam logic [CNT_W-1:0]  WDOG_L = CNT_W'(MAX_CLKS - 1);
    localparam logic [EDGE_W-1:0] EDGE_L = EDGE_W'(EDGE_TARGET - 1);

    typedef struct packed {
        sync_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] edges;
        logic [CNT_W-1:0]  wlen;
        logic              tmode;
        logic              err;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_req) begin
                    if (tmode_in && (wait_in < MIN_L || wait_in > MAX_L)) begin
                        d.err = 1'b1;
                    end else begin
                        d.st    = ST_HOLD;
                        d.cnt   = '0;
                        d.edges = '0;
                        d.wlen  = wait_in;
                        d.tmode = tmode_in;
                        d.err   = 1'b0;
                    end
                end
            end
            ST_HOLD: begin
                d.cnt = q.cnt + 1'b1;
                if (q.tmode) begin
                    if (q.cnt == q.wlen - 1'b1) d.st = ST_RELEASE;
                end else begin
                    if (fall) d.edges = q.edges + 1'b1;
                    if (fall && q.edges == EDGE_L) begin
                        d.st = ST_RELEASE;
                    end else if (q.cnt == WDOG_L) begin
                        d.st  = ST_RELEASE;
                        d.err = 1'b1;
                    end
                end
            end
            ST_RELEASE: d.st = ST_DONE;
            ST_DONE:    d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, edges: '0, wlen: '0, tmode: 1'b0, err: 1'b0};
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_HOLD:    sclk_out = 1'b1;
            ST_RELEASE: sclk_out = 1'b0;
            default:    sclk_out = spi_sclk;
        endcase
    end

    assign busy = (q.st != ST_IDLE);
    assign done = (q.st == ST_DONE);
    assign err  = q.err;

    assert_hold_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && $past(q.st == ST_HOLD)) |-> q.cnt == $past(q.cnt) + 1'b1);
    assert_timer_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && q.tmode) |-> q.wlen >= MIN_L && q.wlen <= MAX_L);
    assert_watchdog_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_HOLD |-> q.cnt <= WDOG_L);
    assert_edge_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !q.tmode) |-> q.edges <= EDGE_L);
    assert_release_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_RELEASE |=> done);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/adc_sync_sequencer.sv
module adc_sync_sequencer #(
    parameter int CONV_CLKS   = 384,
    parameter int MIN_CONV    = 5,
    parameter int MAX_CONV    = 20,
    parameter int EDGE_TARGET = 5,
    parameter int RESYNC_CLKS = 100000,
    parameter int WAIT_W      = $clog2(MAX_CONV * CONV_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_req,
    input  logic              drdy_n,
    input  logic              spi_sclk,
    input  logic              mode_timer,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              resync_en,
    output logic              sclk_out,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic fall;
    logic tick;

    drdy_fall_det u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .drdy_n (drdy_n),
        .fall   (fall)
    );

    resync_timer #(.PERIOD(RESYNC_CLKS)) u_resync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (resync_en),
        .busy  (busy),
        .tick  (tick)
    );

    sync_ctrl_fsm #(
        .CONV_CLKS   (CONV_CLKS),
        .MIN_CONV    (MIN_CONV),
        .MAX_CONV    (MAX_CONV),
        .EDGE_TARGET (EDGE_TARGET),
        .CNT_W       (WAIT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (sync_req | tick),
        .tmode_in  (mode_timer),
        .wait_in   (wait_cfg),
        .fall      (fall),
        .spi_sclk  (spi_sclk),
        .sclk_out  (sclk_out),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    assert_busy_request_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && sync_req) |=> busy);
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: tb/adc_sync_sequencer_test.sv
module adc_sync_sequencer_test;
    localparam int WAIT_W = 13;
    localparam int RESYNC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic drdy_n = 1'b1;
    logic spi_sclk = 1'b0;
    logic mode_timer = 1'b0;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic resync_en = 1'b0;
    logic sclk_out, busy, done, err;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    adc_sync_sequencer #(.RESYNC_CLKS(RESYNC)) uut (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .drdy_n(drdy_n),
        .spi_sclk(spi_sclk), .mode_timer(mode_timer), .wait_cfg(wait_cfg),
        .resync_en(resync_en), .sclk_out(sclk_out), .busy(busy),
        .done(done), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            summary();
        end
    end

    // After the hold: one release cycle, then a done pulse, then back to idle.
    task automatic check_tail(input string tag);
        chk({tag, " R8 release sclk low"}, int'(sclk_out), 0);
        chk({tag, " R8 release busy"}, int'(busy), 1);
        chk({tag, " R8 release no done"}, int'(done), 0);
        @(negedge clk);
        chk({tag, " R8 done pulse"}, int'(done), 1);
        @(negedge clk);
        chk({tag, " R8 done cleared"}, int'(done), 0);
        chk({tag, " R8 busy cleared"}, int'(busy), 0);
        chk({tag, " R8 sclk back to spi"}, int'(sclk_out), int'(spi_sclk));
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        spi_sclk = 1'b1;
        #1;
        chk("R1 follows spi high", int'(sclk_out), 1);
        spi_sclk = 1'b0;
        #1;
        chk("R1 follows spi low", int'(sclk_out), 0);
    endtask

    task automatic test_reject(input int w);
        @(negedge clk);
        mode_timer = 1'b1;
        wait_cfg = WAIT_W'(w);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk("R4 rejected busy", int'(busy), 0);
        chk("R4 rejected err", int'(err), 1);
        spi_sclk = 1'b1;
        #1;
        chk("R4 sclk follows spi", int'(sclk_out), 1);
        spi_sclk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 still idle", int'(busy), 0);
    endtask

    task automatic test_timer(input int w, input logic lvl, input bit poke);
        int n;
        @(negedge clk);
        spi_sclk = lvl;
        mode_timer = 1'b1;
        wait_cfg = WAIT_W'(w);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk("R2 sclk high at start", int'(sclk_out), 1);
        chk("R2 busy at start", int'(busy), 1);
        chk("R11 err cleared", int'(err), 0);
        n = 1;
        while (sclk_out && n < 9000) begin
            @(negedge clk);
            if (poke) sync_req = (n == 100);
            if (sclk_out) n++;
        end
        sync_req = 1'b0;
        chk(poke ? "R9 hold unchanged by request" : "R3 timer hold length", n, w);
        check_tail("timer");
    endtask

    task automatic pulse_drdy();
        @(negedge clk);
        drdy_n = 1'b0;
        repeat (3) @(negedge clk);
        drdy_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic test_edges();
        mode_timer = 1'b0;
        pulse_drdy();   // idle edge, must not count (R6)
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk("R2 edge mode sclk high", int'(sclk_out), 1);
        for (int i = 0; i < 4; i++) pulse_drdy();
        chk("R6 still holding after four hold edges", int'(sclk_out), 1);
        drdy_n = 1'b0;
        @(negedge clk);
        chk("R5 high one sample after fifth edge", int'(sclk_out), 1);
        @(negedge clk);
        chk("R5 high two samples after fifth edge", int'(sclk_out), 1);
        @(negedge clk);
        drdy_n = 1'b1;
        chk("R5 err clear on normal end", int'(err), 0);
        check_tail("edge");
    endtask

    task automatic test_watchdog();
        int n;
        mode_timer = 1'b0;
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        n = 1;
        for (int i = 0; i < 9000 && sclk_out; i++) begin
            drdy_n = !(i == 50 || i == 51 || i == 400 || i == 401);
            @(negedge clk);
            if (sclk_out) n++;
        end
        drdy_n = 1'b1;
        chk("R7 watchdog hold length", n, 7680);
        chk("R7 err set", int'(err), 1);
        check_tail("watchdog");
    endtask

    task automatic test_resync();
        int idle;
        int n;
        @(negedge clk);
        mode_timer = 1'b1;
        wait_cfg = WAIT_W'(1920);
        resync_en = 1'b1;
        idle = 0;
        @(negedge clk);
        while (!busy && idle < 5000) begin
            idle++;
            @(negedge clk);
        end
        resync_en = 1'b0;
        chk("R10 idle clocks before trigger", idle, RESYNC - 1);
        n = 1;
        while (sclk_out && n < 9000) begin
            @(negedge clk);
            if (sclk_out) n++;
        end
        chk("R10 triggered hold length", n, 1920);
        check_tail("resync");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_reject(1919);
        test_reject(7681);
        test_timer(1920, 1'b0, 1'b0);
        test_timer(7680, 1'b1, 1'b1);
        test_edges();
        test_watchdog();
        test_timer(2000, 1'b1, 1'b0);
        test_resync();
        summary();
    end
endmodule